// File: doc/BRIEF.md
# Shared Multiply and Shift Execution Unit

This execution unit serves integer multiplication and all three 32-bit shift kinds from one multiplier array. A shift is rewritten as a multiplication. The shift amount is decoded into a power of two. Either the lower or the upper word of the 64-bit product is then returned. A left shift by n multiplies by 2^n and keeps the low word. A right shift by n > 0 multiplies by 2^(32-n) and keeps the high word. For a logical right shift the operand is treated as unsigned. For an arithmetic right shift it is treated as signed, so the high word carries sign-fill. Each result, whether low or high product word or shifted value, goes out on one result port toward the general register file. The unit keeps no separate product-holding registers.

The unit is unpipelined and runs over several cycles. The pipeline raises `start_i` with an opcode and two operands. The unit then shows `busy_o` and later pulses `done_o` with `result_o`. Only one operation is in flight at a time. The parameter `LATENCY` selects a two- or three-cycle path. With three cycles the product is registered before the word select, which shortens the critical path at the cost of one cycle. Both settings give the same results. Division is not handled.

Top module: `mul_shift_unit`

## Requirements
- R1: Opcode 0 returns the low 32 bits of the product a_i * b_i.
- R2: Opcode 1 returns the upper 32 bits of the signed 64-bit product, and opcode 2 returns the upper 32 bits of the unsigned 64-bit product.
- R3: Opcode 3 returns a_i shifted left by the shift amount, with zeros entering from the right.
- R4: Opcode 4 returns a_i shifted right logically by the shift amount, with zero fill; an amount of 0 returns a_i unchanged.
- R5: Opcode 5 returns a_i shifted right arithmetically, with the vacated upper bits filled with a_i[31]; an amount of 0 returns a_i unchanged.
- R6: The shift amount is b_i[4:0]; bits b_i[31:5] have no effect on a shift result.
- R7: Call the cycle in which start_i is accepted cycle 0. busy_o is high in cycles 1 through LATENCY. done_o is high for exactly one cycle, cycle LATENCY, and result_o is valid in that cycle.
- R8: A start_i pulse while busy_o is high and done_o is low is ignored. It produces no extra done_o pulse and does not change the result of the operation in flight.
- R9: A start_i pulse in the cycle where done_o is high is accepted, so operations can follow back to back.
- R10: result_o is identical for LATENCY 2 and 3, and it holds its value until the next done_o pulse.
- R11: While rst_ni is low and after its release, busy_o, done_o and result_o are 0 until an operation is started.
- R12: Opcodes 6 and 7 behave as opcode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a new operation |
| op_i | input | 3 | Opcode (0 mul low, 1 mul high signed, 2 mul high unsigned, 3 shift left, 4 shift right logical, 5 shift right arithmetic) |
| a_i | input | 32 | First operand, or the value to shift |
| b_i | input | 32 | Second operand, or the shift amount in bits [4:0] |
| busy_o | output | 1 | An operation is in flight |
| done_o | output | 1 | One-cycle pulse: result_o is valid |
| result_o | output | 32 | Result word |

## Verification
The assertions rely on two assumptions about the inputs:

- `rst_ni` is held low before the first clock edge.
- `op_i`, `a_i` and `b_i` are only needed in the cycle of acceptance, and may change at any time.

The stimulus drives every input half a cycle away from the rising edge. It raises `start_i` either when the unit is idle or deliberately in the busy and done cycles, so that the ignore rule and the back-to-back rule are both exercised. Random operands are mixed with directed extreme values, such as full-scale unsigned and negative signed values and shift amounts of 0 and 31. Random garbage goes in the upper bits of the shift amount.

// File: rtl/mul_shift_pkg.sv
package mul_shift_pkg;
  typedef enum logic [2:0] {
    OP_MUL_LO  = 3'd0,
    OP_MULH_S  = 3'd1,
    OP_MULH_U  = 3'd2,
    OP_SHL     = 3'd3,
    OP_SHR_L   = 3'd4,
    OP_SHR_A   = 3'd5,
    OP_RSVD6   = 3'd6,
    OP_RSVD7   = 3'd7
  } msu_op_e;
endpackage

// File: rtl/msu_operand_prep.sv
// Maps an opcode and operands onto signed (XLEN+1)-bit multiplier inputs
// and picks which product word is the result.
module msu_operand_prep
  import mul_shift_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [2:0]         op_i,
  input  logic [XLEN-1:0]    a_i,
  input  logic [XLEN-1:0]    b_i,
  output logic signed [XLEN:0] mul_a_o,
  output logic signed [XLEN:0] mul_b_o,
  output logic               sel_hi_o
);
  localparam int SHW = $clog2(XLEN);
  localparam logic [SHW:0] XLEN_W = (SHW+1)'(XLEN);
  localparam logic [XLEN-1:0] ONE = XLEN'(1);

  logic [SHW-1:0]  amt;
  logic [SHW:0]    amt_r;
  logic [XLEN-1:0] pow_l;
  logic [XLEN-1:0] pow_r;
  logic            amt_zero;

  assign amt      = b_i[SHW-1:0];
  assign amt_zero = (amt == '0);
  assign amt_r    = XLEN_W - {1'b0, amt};
  assign pow_l    = ONE << amt;
  // right shift by n: multiply by 2^(XLEN-n) and take the high word
  assign pow_r    = amt_zero ? ONE : (ONE << amt_r);

  always_comb begin
    mul_a_o  = {1'b0, a_i};
    mul_b_o  = {1'b0, b_i};
    sel_hi_o = 1'b0;
    unique case (msu_op_e'(op_i))
      OP_MULH_S: begin
        mul_a_o  = {a_i[XLEN-1], a_i};
        mul_b_o  = {b_i[XLEN-1], b_i};
        sel_hi_o = 1'b1;
      end
      OP_MULH_U: sel_hi_o = 1'b1;
      OP_SHL:    mul_b_o  = {1'b0, pow_l};
      OP_SHR_L: begin
        mul_b_o  = {1'b0, pow_r};
        sel_hi_o = !amt_zero;
      end
      OP_SHR_A: begin
        mul_a_o  = {a_i[XLEN-1], a_i};
        mul_b_o  = {1'b0, pow_r};
        sel_hi_o = !amt_zero;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/msu_mult_core.sv
// Signed (XLEN+1)x(XLEN+1) multiplier; an optional output register
// splits the path for the longer latency setting.
module msu_mult_core #(
  parameter int XLEN    = 32,
  parameter bit OUT_REG = 1'b0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [XLEN:0] a_i,
  input  logic signed [XLEN:0] b_i,
  output logic [2*XLEN-1:0]    prod_o
);
  logic signed [2*XLEN+1:0] full;
  assign full = a_i * b_i;

  if (OUT_REG) begin : g_reg
    logic [2*XLEN-1:0] prod_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_q <= '0;
      else         prod_q <= full[2*XLEN-1:0];
    end
    assign prod_o = prod_q;
  end else begin : g_comb
    assign prod_o = full[2*XLEN-1:0];
  end
endmodule

// File: rtl/msu_ctrl.sv
// Start/busy/done sequencing for the unpipelined multicycle path.
module msu_ctrl #(
  parameter int LATENCY = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic accept_o,
  output logic load_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CW = (LATENCY > 2) ? $clog2(LATENCY) : 1;
  localparam logic [CW-1:0] LAST = CW'(LATENCY - 2);

  logic          busy_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = start_i && (!busy_q || done_q);
  assign load_o   = busy_q && !done_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (accept_o) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (done_q) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R7
  done_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> busy_q);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R7
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |-> ##LATENCY done_q);
  // R8
  no_early_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !done_q);
endmodule

// File: rtl/mul_shift_unit.sv
module mul_shift_unit
  import mul_shift_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int LATENCY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [2:0]      op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [XLEN-1:0] result_o
);
  localparam bit OUT_REG = (LATENCY >= 3);

  logic signed [XLEN:0] prep_a, prep_b;
  logic                 prep_hi;
  logic signed [XLEN:0] opa_q, opb_q;
  logic                 hi_q;
  logic [2*XLEN-1:0]    prod;
  logic [XLEN-1:0]      res_q;
  logic                 accept, load;

  msu_operand_prep #(.XLEN(XLEN)) u_prep (
    .op_i     (op_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .mul_a_o  (prep_a),
    .mul_b_o  (prep_b),
    .sel_hi_o (prep_hi)
  );

  msu_ctrl #(.LATENCY(LATENCY)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .load_o   (load),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opa_q <= '0;
      opb_q <= '0;
      hi_q  <= 1'b0;
    end else if (accept) begin
      opa_q <= prep_a;
      opb_q <= prep_b;
      hi_q  <= prep_hi;
    end
  end

  msu_mult_core #(.XLEN(XLEN), .OUT_REG(OUT_REG)) u_mult (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .a_i    (opa_q),
    .b_i    (opb_q),
    .prod_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   res_q <= '0;
    else if (load) res_q <= hi_q ? prod[2*XLEN-1:XLEN] : prod[XLEN-1:0];
  end

  assign result_o = res_q;

  // R8
  operands_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o && !start_i) |=> ($stable(opa_q) && $stable(opb_q) && $stable(hi_q)));
  // R10
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> $stable(result_o));
  // R7
  idle_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !done_o);
endmodule

// File: tb/sim_mul_shift_unit.sv
`timescale 1ns/1ps
module sim_mul_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [31:0] a = '0, b = '0;
  logic        busy0, done0, busy1, done1;
  logic [31:0] res0, res1;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  mul_shift_unit #(.XLEN(32), .LATENCY(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .busy_o(busy0), .done_o(done0), .result_o(res0));
  mul_shift_unit #(.XLEN(32), .LATENCY(3)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .busy_o(busy1), .done_o(done1), .result_o(res1));

  function automatic logic [31:0] ref_f(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [63:0] pu;
    logic signed [63:0] ps;
    int n;
    pu = {32'b0, x} * {32'b0, y};
    ps = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
    n  = int'(y[4:0]);
    case (o)
      3'd1: return ps[63:32];
      3'd2: return pu[63:32];
      3'd3: return x << n;
      3'd4: return x >> n;
      3'd5: return $unsigned($signed(x) >>> n);
      default: return pu[31:0];
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd1, 3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6, 3'd7: return "R12";
      default: return "R1";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Issue one operation from idle and check both instances.
  task automatic do_op(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
    logic [31:0] exp;
    bit got0, got1;
    int cyc;
    exp = ref_f(o, x, y);
    @(negedge clk);
    start = 1'b1; op = o; a = x; b = y;
    @(negedge clk);
    start = 1'b0; op = $urandom; a = $urandom; b = $urandom;
    cyc = 1; got0 = 0; got1 = 0;
    chk(busy0 && busy1, "R7", {30'b0, busy1, busy0}, 32'h3);
    while (!(got0 && got1) && cyc < 8) begin
      if (done0 && !got0) begin
        got0 = 1;
        chk(cyc == 2, "R7", cyc, 2);
        chk(res0 == exp, tag_of(o), res0, exp);
      end
      if (done1 && !got1) begin
        got1 = 1;
        chk(cyc == 3, "R7", cyc, 3);
        chk(res1 == exp, "R10", res1, exp);
      end
      if (!(got0 && got1)) begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(got0 && got1, "R7", {30'b0, got1, got0}, 32'h3);
    @(negedge clk);
    chk(!done1 && res1 == exp && res0 == exp, "R10", res1, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!busy0 && !done0 && res0 == 0 && !busy1 && !done1 && res1 == 0, "R11", res0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy0 && !done0 && res0 == 0, "R11", res0, 0);

    // directed corners
    do_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R1
    do_op(3'd1, 32'h8000_0000, 32'h8000_0000);   // R2
    do_op(3'd1, 32'hFFFF_FFFF, 32'h0000_0002);   // R2
    do_op(3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);   // R2
    do_op(3'd3, 32'h8000_0001, 32'h0000_001F);   // R3
    do_op(3'd3, 32'h1234_5678, 32'h0000_0000);   // R3
    do_op(3'd4, 32'hF000_000F, 32'h0000_0000);   // R4 amount 0
    do_op(3'd4, 32'h8000_0000, 32'h0000_001F);   // R4
    do_op(3'd5, 32'h8000_0000, 32'h0000_001F);   // R5
    do_op(3'd5, 32'h9ABC_DEF0, 32'h0000_0000);   // R5 amount 0
    do_op(3'd5, 32'h7FFF_FFFF, 32'h0000_0004);   // R5 positive
    do_op(3'd4, 32'hDEAD_BEEF, 32'hFFFF_FFE4);   // R6 upper bits set
    do_op(3'd5, 32'hDEAD_BEEF, 32'hA5A5_A5E8);   // R6
    do_op(3'd3, 32'h0000_00FF, 32'h7FFF_FF28);   // R6
    do_op(3'd6, 32'h0001_0003, 32'h0002_0005);   // R12
    do_op(3'd7, 32'hFFFF_FFFE, 32'h0000_0003);   // R12

    // R8: start while busy is ignored
    begin
      int n_done;
      @(negedge clk);
      start = 1'b1; op = 3'd3; a = 32'h1; b = 32'h4;
      @(negedge clk);
      op = 3'd0; a = 32'h5; b = 32'h7;          // cycle 1: busy, not done
      @(negedge clk);
      start = 1'b0;
      n_done = 0;
      if (done0) begin
        n_done++;
        chk(res0 == 32'h10, "R8", res0, 32'h10);
      end
      repeat (5) begin
        @(negedge clk);
        if (done0) n_done++;
        if (done1) chk(res1 == 32'h10, "R8", res1, 32'h10);
      end
      chk(n_done == 1, "R8", n_done, 1);
      chk(!busy0 && !busy1 && res0 == 32'h10, "R8", res0, 32'h10);
    end

    // R9: start in the done cycle is accepted (u0, latency 2)
    begin
      @(negedge clk);
      start = 1'b1; op = 3'd2; a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);                            // cycle 2: done
      chk(done0 && res0 == 32'hFFFF_FFFE, "R9", res0, 32'hFFFF_FFFE);
      start = 1'b1; op = 3'd5; a = 32'h8000_0000; b = 32'd31;
      @(negedge clk);                            // cycle 3
      start = 1'b0;
      chk(!done0 && busy0, "R9", {30'b0, busy0, done0}, 32'h2);
      @(negedge clk);                            // cycle 4: second done
      chk(done0 && res0 == 32'hFFFF_FFFF, "R9", res0, 32'hFFFF_FFFF);
      repeat (4) @(negedge clk);
    end

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [2:0] o;
      logic [31:0] x, y;
      o = 3'($urandom_range(0, 7));
      x = $urandom;
      y = $urandom;
      if ((i % 8) == 0) x = {x[31], 31'h0};
      do_op(o, x, y);
    end

    summary();
    $finish;
  end
endmodule